// File: doc/BRIEF.md
# Dual-Precision Integer Execution Stage

This block is one integer execution stage with two copies of its arithmetic and logic unit. The exact unit always gives the correct answer. The shadow unit stands for a copy of the hardware running at a low supply voltage, where results can be wrong. It models that by flipping single bits in its results. Each issued operation carries a precision bit next to its opcode. The bit sends the result of that one operation through the exact unit or through the shadow unit, and the registered output returns the bit as a tag. The flag path always comes from the exact unit. An approximate operation can therefore return a wrong value, but it never raises a flag that differs from the exact version.

Errors come from a seeded 32-bit Galois LFSR. The LFSR steps once for each approximate operation. A programmable threshold sets how often the shadow result is corrupted. A threshold of zero turns the shadow unit into an exact copy of the exact unit. The seed can be loaded, so a run of errors can be repeated exactly.

Top module: `dpx_exec_unit`

## Requirements
- R1: Opcode encodings and results, for an operation issued with the precision bit low: 0 gives a+b, 1 gives a-b, 2 gives a AND b, 3 gives a OR b, 4 gives a XOR b, 5 gives a shifted left logically, 6 gives a shifted right logically, 7 gives a shifted right arithmetically. All arithmetic wraps modulo 2^DATA_W.
- R2: An operation issued with in_valid high in one clock cycle appears on the outputs with out_valid high after exactly one rising edge. A cycle with in_valid low gives out_valid low one edge later. Back-to-back operations are accepted on every cycle.
- R3: out_approx equals the precision bit that was issued with the operation (1 = approximate, 0 = exact).
- R4: When flip_threshold is 0, an approximate operation returns the same result as the exact operation.
- R5: Let S be the LFSR state at the moment an approximate operation issues. If S[15:0] < flip_threshold (unsigned), the result differs from the exact result in exactly bit (S[31:16] mod DATA_W). Otherwise the result equals the exact result.
- R6: The LFSR steps only when an approximate operation issues. The step is next = (S>>1) XOR (S[0] ? 32'hD0000001 : 0). Exact operations and idle cycles leave the state unchanged.
- R7: A cycle with seed_load high sets the LFSR state to seed_value at the next edge. A seed of zero is replaced by 1.
- R8: out_ovf reports signed two's-complement overflow of operations 0 and 1. It is taken from the exact unit for both precisions, so a bit flip on the approximate path never changes it. It is 0 for opcodes 2 to 7.
- R9: After reset, out_valid, out_result, out_approx and out_ovf are 0 and the LFSR state is RESET_SEED (default 1).
- R10: Shift opcodes use only the low log2(DATA_W) bits of b as the shift amount. The higher bits of b are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | An operation issues this cycle |
| in_op | input | 3 | Opcode (see R1) |
| in_approx | input | 1 | Precision bit: 1 = approximate path |
| in_a | input | DATA_W | First operand |
| in_b | input | DATA_W | Second operand / shift amount |
| seed_load | input | 1 | Load the LFSR from seed_value |
| seed_value | input | 32 | LFSR seed |
| flip_threshold | input | 16 | Bit-flip probability threshold |
| out_valid | output | 1 | Registered result is valid |
| out_result | output | DATA_W | Registered result |
| out_approx | output | 1 | Precision tag of the result |
| out_ovf | output | 1 | Signed overflow flag from the exact unit |

## Verification
The hardest case to reach from the ports is a bit flip on an operation whose exact result sets the overflow flag. It has to be shown that the flag still follows the exact arithmetic. The bench gets there by loading a seed of zero, which is forced to 1. With a threshold of 0xFFFF, the very next approximate add then flips bit 0 of 0x7FFFFFFF+1, and the flag must stay set. Other seeds, mixed with exact operations, show that the error stream advances only on approximate issues.

// File: rtl/dpx_pkg.sv
package dpx_pkg;

    typedef enum logic [2:0] {
        OP_ADD = 3'd0,
        OP_SUB = 3'd1,
        OP_AND = 3'd2,
        OP_OR  = 3'd3,
        OP_XOR = 3'd4,
        OP_SLL = 3'd5,
        OP_SRL = 3'd6,
        OP_SRA = 3'd7
    } dpx_op_e;

    localparam int unsigned LFSR_W = 32;
    localparam logic [LFSR_W-1:0] LFSR_POLY = 32'hD000_0001;

    // One right-shifting Galois step.
    function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
        return s[0] ? ((s >> 1) ^ LFSR_POLY) : (s >> 1);
    endfunction

endpackage

// File: rtl/dpx_alu.sv
module dpx_alu
    import dpx_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  dpx_op_e           op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] res,
    output logic              ovf
);
    localparam int unsigned SH_W = $clog2(DATA_W);

    logic [SH_W-1:0]   shamt;
    logic [DATA_W-1:0] sum;
    logic [DATA_W-1:0] diff;

    always_comb begin
        shamt = b[SH_W-1:0];
        sum   = a + b;
        diff  = a - b;
        res   = '0;
        ovf   = 1'b0;
        unique case (op)
            OP_ADD: begin
                res = sum;
                ovf = (a[DATA_W-1] == b[DATA_W-1]) && (sum[DATA_W-1] != a[DATA_W-1]);
            end
            OP_SUB: begin
                res = diff;
                ovf = (a[DATA_W-1] != b[DATA_W-1]) && (diff[DATA_W-1] != a[DATA_W-1]);
            end
            OP_AND: res = a & b;
            OP_OR:  res = a | b;
            OP_XOR: res = a ^ b;
            OP_SLL: res = a << shamt;
            OP_SRL: res = a >> shamt;
            OP_SRA: res = $signed(a) >>> shamt;
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/dpx_flip.sv
module dpx_flip #(
    parameter int unsigned DATA_W = 32
) (
    input  logic [DATA_W-1:0] raw,
    input  logic [31:0]       rnd,
    input  logic [15:0]       threshold,
    output logic [DATA_W-1:0] data
);
    logic              hit;
    logic [15:0]       idx;
    logic [DATA_W-1:0] mask;

    always_comb begin
        hit  = rnd[15:0] < threshold;
        idx  = rnd[31:16] % 16'(DATA_W);
        mask = {{(DATA_W-1){1'b0}}, 1'b1} << idx;
        data = hit ? (raw ^ mask) : raw;
    end
endmodule

// File: rtl/dpx_lfsr.sv
module dpx_lfsr
    import dpx_pkg::*;
#(
    parameter logic [LFSR_W-1:0] RESET_SEED = 32'h1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [LFSR_W-1:0] seed,
    input  logic              advance,
    output logic [LFSR_W-1:0] state
);
    logic [LFSR_W-1:0] state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (load) begin
            state_d = (seed == '0) ? {{(LFSR_W-1){1'b0}}, 1'b1} : seed;
        end else if (advance) begin
            state_d = lfsr_step(state_q);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RESET_SEED;
        else        state_q <= state_d;
    end

    assign state = state_q;

    p_hold_when_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !advance) |=> $stable(state_q))
        else $error("LFSR moved without an approximate issue");

    p_nonzero_state_r7: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (state_q != '0))
        else $error("LFSR loaded with zero");

endmodule

// File: rtl/dpx_exec_unit.sv
module dpx_exec_unit
    import dpx_pkg::*;
#(
    parameter int unsigned       DATA_W     = 32,
    parameter logic [LFSR_W-1:0] RESET_SEED = 32'h1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [2:0]        in_op,
    input  logic              in_approx,
    input  logic [DATA_W-1:0] in_a,
    input  logic [DATA_W-1:0] in_b,
    input  logic              seed_load,
    input  logic [31:0]       seed_value,
    input  logic [15:0]       flip_threshold,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_result,
    output logic              out_approx,
    output logic              out_ovf
);
    typedef struct packed {
        logic              valid;
        logic              approx;
        logic              ovf;
        logic [DATA_W-1:0] result;
    } stage_t;

    stage_t stage_d, stage_q;

    dpx_op_e           op;
    logic              shadow_en;
    logic [DATA_W-1:0] shadow_a, shadow_b;
    logic [DATA_W-1:0] exact_res, shadow_raw, shadow_out;
    logic              exact_ovf, shadow_ovf_unused;
    logic [31:0]       rnd;

    assign op        = dpx_op_e'(in_op);
    assign shadow_en = in_valid && in_approx;
    // Operand isolation: the shadow copy only toggles on approximate issues.
    assign shadow_a  = shadow_en ? in_a : '0;
    assign shadow_b  = shadow_en ? in_b : '0;

    dpx_alu #(.DATA_W(DATA_W)) u_exact_alu (
        .op (op), .a (in_a), .b (in_b), .res (exact_res), .ovf (exact_ovf)
    );

    dpx_alu #(.DATA_W(DATA_W)) u_shadow_alu (
        .op (op), .a (shadow_a), .b (shadow_b), .res (shadow_raw), .ovf (shadow_ovf_unused)
    );

    dpx_lfsr #(.RESET_SEED(RESET_SEED)) u_lfsr (
        .clk (clk), .rst_n (rst_n), .load (seed_load), .seed (seed_value),
        .advance (shadow_en), .state (rnd)
    );

    dpx_flip #(.DATA_W(DATA_W)) u_flip (
        .raw (shadow_raw), .rnd (rnd), .threshold (flip_threshold), .data (shadow_out)
    );

    always_comb begin
        stage_d       = stage_q;
        stage_d.valid = in_valid;
        if (in_valid) begin
            stage_d.approx = in_approx;
            stage_d.result = in_approx ? shadow_out : exact_res;
            stage_d.ovf    = exact_ovf;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= stage_d;
    end

    assign out_valid  = stage_q.valid;
    assign out_result = stage_q.result;
    assign out_approx = stage_q.approx;
    assign out_ovf    = stage_q.ovf;

    p_tag_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_valid && (out_approx == $past(in_approx))))
        else $error("precision tag or latency wrong");

    p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid)
        else $error("spurious valid");

    p_single_flip_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(shadow_raw ^ shadow_out) <= 1)
        else $error("more than one bit flipped");

    p_zero_thr_exact_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (flip_threshold == 16'd0) |-> (shadow_out == shadow_raw))
        else $error("flip with zero threshold");

    p_flag_arith_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op != 3'd0 && in_op != 3'd1) |=> !out_ovf)
        else $error("overflow flag on non-arithmetic op");

endmodule

// File: tb/dpx_exec_unit_bench.sv
module dpx_exec_unit_bench;
    localparam int W = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [2:0]    in_op = '0;
    logic          in_approx = 1'b0;
    logic [W-1:0]  in_a = '0, in_b = '0;
    logic          seed_load = 1'b0;
    logic [31:0]   seed_value = '0;
    logic [15:0]   flip_threshold = '0;
    logic          out_valid, out_approx, out_ovf;
    logic [W-1:0]  out_result;

    int compared = 0;
    int mismatched = 0;
    bit done = 0;
    logic [31:0] lfsr_m;

    always #5 clk = ~clk;

    dpx_exec_unit u_dpx_exec_unit (
        .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .in_op (in_op),
        .in_approx (in_approx), .in_a (in_a), .in_b (in_b),
        .seed_load (seed_load), .seed_value (seed_value), .flip_threshold (flip_threshold),
        .out_valid (out_valid), .out_result (out_result), .out_approx (out_approx),
        .out_ovf (out_ovf)
    );

    // {op, a, b, expected result, expected overflow}
    localparam logic [99:0] VEC [12] = '{
        {3'd0, 32'h7FFF_FFFF, 32'h0000_0001, 32'h8000_0000, 1'b1},
        {3'd0, 32'h0000_0005, 32'h0000_0007, 32'h0000_000C, 1'b0},
        {3'd1, 32'h0000_0003, 32'h0000_0005, 32'hFFFF_FFFE, 1'b0},
        {3'd1, 32'h8000_0000, 32'h0000_0001, 32'h7FFF_FFFF, 1'b1},
        {3'd2, 32'hF0F0_F0F0, 32'h0FF0_0FF0, 32'h00F0_00F0, 1'b0},
        {3'd3, 32'h1234_0000, 32'h0000_5678, 32'h1234_5678, 1'b0},
        {3'd4, 32'hFFFF_0000, 32'h0F0F_0F0F, 32'hF0F0_0F0F, 1'b0},
        {3'd5, 32'h0000_0001, 32'h0000_001F, 32'h8000_0000, 1'b0},
        {3'd5, 32'h0000_0003, 32'h0000_0021, 32'h0000_0006, 1'b0},
        {3'd6, 32'h8000_0000, 32'h0000_0004, 32'h0800_0000, 1'b0},
        {3'd7, 32'h8000_0000, 32'h0000_0004, 32'hF800_0000, 1'b0},
        {3'd7, 32'h7FFF_FFF0, 32'h0000_0024, 32'h07FF_FFFF, 1'b0}
    };

    function automatic logic [31:0] m_step(input logic [31:0] s);
        return s[0] ? ((s >> 1) ^ 32'hD000_0001) : (s >> 1);
    endfunction

    function automatic logic [W:0] m_alu(input logic [2:0] op, input logic [W-1:0] a, input logic [W-1:0] b);
        logic [W-1:0] r;
        logic v;
        v = 1'b0;
        case (op)
            3'd0: begin r = a + b; v = (a[W-1] == b[W-1]) && (r[W-1] != a[W-1]); end
            3'd1: begin r = a - b; v = (a[W-1] != b[W-1]) && (r[W-1] != a[W-1]); end
            3'd2: r = a & b;
            3'd3: r = a | b;
            3'd4: r = a ^ b;
            3'd5: r = a << b[4:0];
            3'd6: r = a >> b[4:0];
            default: r = $signed(a) >>> b[4:0];
        endcase
        return {v, r};
    endfunction

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive at a falling edge, sample at the next falling edge (one rising edge later).
    task automatic issue(input logic [2:0] op, input logic ap, input logic [W-1:0] a, input logic [W-1:0] b);
        @(negedge clk);
        in_valid = 1'b1; in_op = op; in_approx = ap; in_a = a; in_b = b;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // Predicts approximate result from the model LFSR, then steps it.
    task automatic run_approx(input string req, input logic [2:0] op, input logic [W-1:0] a, input logic [W-1:0] b);
        logic [W:0] ref_v;
        logic [W-1:0] exp;
        ref_v = m_alu(op, a, b);
        exp = ref_v[W-1:0];
        if (lfsr_m[15:0] < flip_threshold) exp = exp ^ (32'h1 << (lfsr_m[31:16] % 16'd32));
        issue(op, 1'b1, a, b);
        check(req, out_result, exp);
        check({req, " tag R3"}, {31'd0, out_approx}, 32'd1);
        check({req, " flag R8"}, {31'd0, out_ovf}, {31'd0, ref_v[W]});
        lfsr_m = m_step(lfsr_m);
    endtask

    task automatic run_exact(input string req, input logic [2:0] op, input logic [W-1:0] a, input logic [W-1:0] b);
        logic [W:0] ref_v;
        ref_v = m_alu(op, a, b);
        issue(op, 1'b0, a, b);
        check(req, out_result, ref_v[W-1:0]);
        check({req, " tag R3"}, {31'd0, out_approx}, 32'd0);
    endtask

    task automatic load_seed(input logic [31:0] s);
        @(negedge clk);
        seed_load = 1'b1; seed_value = s;
        @(negedge clk);
        seed_load = 1'b0;
        lfsr_m = (s == 32'd0) ? 32'd1 : s;
    endtask

    initial begin
        lfsr_m = 32'd1;
        repeat (3) @(negedge clk);
        // R9: reset state
        check("R9 valid", {31'd0, out_valid}, 32'd0);
        check("R9 result", out_result, 32'd0);
        check("R9 tag", {31'd0, out_approx}, 32'd0);
        check("R9 flag", {31'd0, out_ovf}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1, R4, R8, R10: table walk on both paths with threshold zero
        flip_threshold = 16'd0;
        for (int i = 0; i < 12; i++) begin
            logic [2:0] op;
            logic [31:0] a, b, e;
            logic v;
            {op, a, b, e, v} = VEC[i];
            issue(op, 1'b0, a, b);
            check("R1 exact result", out_result, e);
            check("R8 exact flag", {31'd0, out_ovf}, {31'd0, v});
            check("R2 valid", {31'd0, out_valid}, 32'd1);
            check("R3 exact tag", {31'd0, out_approx}, 32'd0);
            issue(op, 1'b1, a, b);
            check("R4 approx at zero threshold", out_result, e);
            check("R8 approx flag", {31'd0, out_ovf}, {31'd0, v});
            check("R3 approx tag", {31'd0, out_approx}, 32'd1);
            lfsr_m = m_step(lfsr_m);
        end

        // R2: idle cycle drops valid
        @(negedge clk);
        check("R2 idle", {31'd0, out_valid}, 32'd0);

        // R5, R6: heavy errors, exact ops interleaved must not step the LFSR
        flip_threshold = 16'hFFFF;
        run_approx("R5 flip a", 3'd0, 32'h0000_1000, 32'h0000_0234);
        run_exact("R6 exact between", 3'd4, 32'hAAAA_5555, 32'h0F0F_F0F0);
        run_approx("R5 flip b", 3'd2, 32'hFFFF_FFFF, 32'h1357_9BDF);
        run_exact("R6 exact between2", 3'd1, 32'h0000_0010, 32'h0000_0001);
        run_approx("R5 flip c", 3'd6, 32'hFFFF_0000, 32'h0000_0008);
        run_approx("R5 flip d", 3'd3, 32'h0000_0000, 32'h0000_0000);

        // R7, R8: zero seed becomes 1 -> bit 0 flips on an overflowing add
        load_seed(32'd0);
        issue(3'd0, 1'b1, 32'h7FFF_FFFF, 32'h0000_0001);
        check("R7 zero seed flip", out_result, 32'h8000_0001);
        check("R8 flag kept under flip", {31'd0, out_ovf}, 32'd1);
        lfsr_m = m_step(lfsr_m);

        // R5, R7: mid threshold with a loaded seed
        load_seed(32'hDEAD_BEEF);
        flip_threshold = 16'h8000;
        for (int k = 0; k < 8; k++) begin
            run_approx("R5 mid threshold", 3'(k), 32'h1234_5678 + 32'(k), 32'h0000_0003);
            run_exact("R6 exact mix", 3'(k), 32'h0F00_00F0, 32'(k));
        end

        // R2: back-to-back issues
        @(negedge clk);
        in_valid = 1'b1; in_approx = 1'b0; in_op = 3'd0; in_a = 32'd10; in_b = 32'd20;
        @(negedge clk);
        check("R2 back-to-back first", out_result, 32'd30);
        in_op = 3'd1; in_a = 32'd10; in_b = 32'd20;
        @(negedge clk);
        in_valid = 1'b0;
        check("R2 back-to-back second", out_result, 32'hFFFF_FFF6);
        check("R2 back-to-back valid", {31'd0, out_valid}, 32'd1);

        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            compared++;
            mismatched++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule